// File: doc/BRIEF.md
# Serial BCD Digit Validity Checker

The block takes a serial bit stream, one bit per clock in each cycle that the bit-valid strobe is high. It cuts the stream into back-to-back, non-overlapping groups of four bits. When a group is complete it reports whether those four bits form a legal decimal digit (codes 0 to 9) or one of the six unused codes (10 to 15). The first bit of a group is its most significant bit.

A code is illegal exactly when it matches 11xx or 101x, reading from the first bit received, where x means the bit has no effect. The last bit of a group therefore never affects the verdict. Each earlier position of a group is held in its own flip-flop. The verdict is a small AND/OR term over those flip-flops, taken as the final bit arrives.

The input is a plain valid strobe and has no ready signal. The block accepts a bit in every cycle that the strobe is high and never applies back-pressure, so a source may stream bits on consecutive cycles without limit. Idle cycles with the strobe low may fall anywhere inside or between groups.

Top module: `bcd_serial_check`

## Requirements
- R1: While reset is high at a clock edge, the block clears the bit position and the stored bits, and after that edge `group_done` and `digit_ok` are both 0.
- R2: Valid bits are counted in groups of four. `group_done` is 1 in the cycle after the clock edge that takes the fourth valid bit of a group, and is 0 in every other cycle.
- R3: The first valid bit of a group is bit 3 (the MSB) of the code and the fourth is bit 0. For codes 0 to 9, `digit_ok` is 1 in the `group_done` cycle.
- R4: For codes 10 to 15 (bit patterns 101x and 11xx, MSB first), `digit_ok` is 0 in the `group_done` cycle.
- R5: A cycle with `bit_valid` low has no effect, whatever `ser_din` is. It does not move the bit position, it does not change a stored bit, and it does not raise `group_done`.
- R6: `digit_ok` keeps its value in every cycle in which `group_done` is 0.
- R7: A reset in the middle of a group discards the partial group, and the next valid bit starts a new group as its MSB.
- R8: `group_done` is never high in two consecutive cycles, including when groups arrive back to back without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial data bit, MSB of each group first |
| bit_valid | input | 1 | Marks `ser_din` as a bit of the stream in this cycle |
| group_done | output | 1 | One-cycle pulse after a four-bit group is complete |
| digit_ok | output | 1 | 1 when the last completed group was a code from 0 to 9 |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- **All sixteen codes in a row.** It plays every code back to back. A design that mirrors the bit order or matches the wrong pattern would pass 1010 or 1011, or would reject 8 or 9.
- **Idle cycles with junk data.** It inserts random idle cycles with random data inside groups. A design that counts or stores bits without looking at the strobe would shift its framing, and its pulse would come at the wrong cycle.
- **Reset inside a group.** It resets partway through a group and then sends a legal digit. A design that kept its position across reset would complete a false group early and reject that digit.
- **Verdict between pulses.** It checks that `digit_ok` stays frozen between pulses. A flag that followed the partial bits would change in the middle of a group.

// File: rtl/bcd_chk_pkg.sv
package bcd_chk_pkg;
  localparam int GROUP_W   = 4;
  localparam int POS_W     = $clog2(GROUP_W);
  localparam int STORE_W   = GROUP_W - 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(GROUP_W - 1);
endpackage

// File: rtl/bcd_pos_counter.sv
module bcd_pos_counter
  import bcd_chk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  output logic [POS_W-1:0] pos,
  output logic             last_bit
);
  always_ff @(posedge clk) begin
    if (rst)            pos <= '0;
    else if (bit_valid) pos <= (pos == LAST_POS) ? '0 : pos + 1'b1;
  end

  assign last_bit = bit_valid && (pos == LAST_POS);

  // R5: an idle cycle leaves the position where it was
  a_r5_idle_holds_pos: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(pos));
  // R2: the position wraps to 0 after the fourth bit
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && pos == LAST_POS) |=> (pos == '0));
  // R1: reset clears the position
  a_r1_reset_pos: assert property (@(posedge clk)
    rst |=> (pos == '0));
endmodule

// File: rtl/bcd_slot_store.sv
module bcd_slot_store
  import bcd_chk_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_valid,
  input  logic               ser_din,
  input  logic [POS_W-1:0]   pos,
  output logic [STORE_W-1:0] slot
);
  for (genvar i = 0; i < STORE_W; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)
        slot[i] <= 1'b0;
      else if (bit_valid && pos == POS_W'(i))
        slot[i] <= ser_din;
    end
  end

  // R5: with no valid bit, nothing that is stored changes
  a_r5_idle_holds_slots: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(slot));
endmodule

// File: rtl/bcd_code_judge.sv
module bcd_code_judge
  import bcd_chk_pkg::*;
(
  input  logic [STORE_W-1:0] slot,
  output logic               legal
);
  logic b3, b2, b1;
  logic hit_11xx, hit_101x;

  always_comb begin
    b3 = slot[0];
    b2 = slot[1];
    b1 = slot[2];
    hit_11xx = b3 & b2;
    hit_101x = b3 & ~b2 & b1;
    legal = ~(hit_11xx | hit_101x);
  end
endmodule

// File: rtl/bcd_serial_check.sv
module bcd_serial_check
  import bcd_chk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ser_din,
  input  logic bit_valid,
  output logic group_done,
  output logic digit_ok
);
  logic [POS_W-1:0]   pos;
  logic               last_bit;
  logic [STORE_W-1:0] slot;
  logic               legal;

  bcd_pos_counter u_pos (
    .clk(clk), .rst(rst), .bit_valid(bit_valid),
    .pos(pos), .last_bit(last_bit)
  );

  bcd_slot_store u_store (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .ser_din(ser_din),
    .pos(pos), .slot(slot)
  );

  bcd_code_judge u_judge (
    .slot(slot), .legal(legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      group_done <= 1'b0;
      digit_ok   <= 1'b0;
    end else begin
      group_done <= last_bit;
      if (last_bit) digit_ok <= legal;
    end
  end

  // R8: a pulse lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    group_done |=> !group_done);
  // R2: a pulse is always caused by a valid bit one edge earlier
  a_r2_pulse_after_bit: assert property (@(posedge clk) disable iff (rst)
    group_done |-> $past(bit_valid));
  // R6: the verdict is frozen between pulses
  a_r6_verdict_hold: assert property (@(posedge clk) disable iff (rst)
    !group_done |-> $stable(digit_ok));
  // R1: reset leaves both outputs low
  a_r1_reset_outputs: assert property (@(posedge clk)
    rst |=> (!group_done && !digit_ok));
endmodule

// File: tb/bcd_serial_check_test.sv
`timescale 1ns/1ps
module bcd_serial_check_test;
  logic clk = 0;
  logic rst, ser_din, bit_valid;
  logic group_done, digit_ok;
  int checks = 0, errors = 0;
  logic last_ok;
  bit finished = 0;

  always #2 clk = ~clk;

  bcd_serial_check uut (
    .clk(clk), .rst(rst), .ser_din(ser_din), .bit_valid(bit_valid),
    .group_done(group_done), .digit_ok(digit_ok)
  );

  function automatic logic exp_legal(input logic [3:0] code);
    return code <= 4'd9;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_code(input logic [3:0] code, input int max_gap);
    for (int i = 3; i >= 0; i--) begin
      int gaps = (max_gap > 0) ? int'($urandom_range(max_gap)) : 0;
      for (int g = 0; g < gaps; g++) begin
        bit_valid = 0; ser_din = 1'($urandom);
        step();
        check("R5 idle no pulse", group_done, 1'b0);
        check("R6 verdict held", digit_ok, last_ok);
      end
      bit_valid = 1; ser_din = code[i];
      step();
      if (i == 0) begin
        check("R2 pulse after 4th bit", group_done, 1'b1);
        check(exp_legal(code) ? "R3 legal code" : "R4 illegal code",
              digit_ok, exp_legal(code));
        last_ok = exp_legal(code);
      end else begin
        check("R8/R2 no pulse mid group", group_done, 1'b0);
        check("R6 verdict held", digit_ok, last_ok);
      end
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; ser_din = 0; bit_valid = 0;
    step(); step();
    check("R1 reset done", group_done, 1'b0);
    check("R1 reset ok", digit_ok, 1'b0);
    rst = 0; last_ok = 0;

    // all sixteen codes back to back
    for (int c = 0; c < 16; c++) send_code(4'(c), 0);

    // illegal then idle with junk
    send_code(4'd11, 3);
    bit_valid = 0;
    for (int k = 0; k < 5; k++) begin
      ser_din = 1'($urandom); step();
      check("R5 idle no pulse", group_done, 1'b0);
      check("R6 verdict held", digit_ok, last_ok);
    end

    // R7: reset mid group
    bit_valid = 1; ser_din = 1; step();
    ser_din = 1; step();
    bit_valid = 0; rst = 1; step();
    check("R7/R1 reset mid group done", group_done, 1'b0);
    check("R7/R1 reset mid group ok", digit_ok, 1'b0);
    rst = 0; last_ok = 0;
    send_code(4'd5, 0);
    send_code(4'd9, 2);
    send_code(4'd10, 2);

    // random traffic
    for (int n = 0; n < 300; n++) send_code(4'($urandom), 3);

    bit_valid = 0; step();
    check("R8 pulse ends", group_done, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule